// File: doc/BRIEF.md
# Sensor Node Operating Mode Sequencer

This block is a finite state machine that decides the operating mode of a battery-powered wearable sensor node. Its inputs are command strobes that an upstream decoder produces from base station packets (configuration, start, pre-alarm, stop), a 1 ms scheduler tick and a flag saying that a task is pending. Its outputs are the present mode, a sleep request for the power controller, an acquisition enable, a one-cycle mode-change pulse and the value last loaded into its interval timer.

After reset the node is in an initialization mode. It sleeps there for a programmable wake interval, counted in ticks and wide enough for 10 s to 5 min. It then wakes into a listen window. If at least one configuration packet arrives in that window, a later start command moves the node into data mode. If no configuration packet arrives before the window ends, the node returns to initialization. In data mode every tick polls the task flag. When no task is pending, the node enters sleep for a programmed number of ticks and then comes back. A pre-alarm command moves the node into an alarm mode that keeps acquiring and never asks for sleep. A stop command sends the node back to initialization from any active mode. All pins are plain control and status lines. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `node_mode_seq`

## Requirements
- R1: A synchronous active-high reset puts the mode at INIT (mode code 0), with sleep_req=1, acq_en=0, mode_chg=0, and tmr_load equal to wake_ivl. The mode codes are INIT=0, LISTEN=1, DATA=2, SLEEP=3, ALARM=4.
- R2: In INIT the node moves to LISTEN on the wake_ivl-th tick after it entered INIT. A value of 0 counts as 1. tmr_load shows the interval loaded on entry to the current mode: wake_ivl in INIT, LISTEN_TICKS in LISTEN, sleep_len in SLEEP, and 0 in DATA and ALARM.
- R3: In LISTEN a start strobe moves the node to DATA only after a cfg_pkt strobe has been seen in the same LISTEN stay. An earlier start strobe is ignored.
- R4: In LISTEN, if no cfg_pkt has been seen, the LISTEN_TICKS-th tick returns the node to INIT. After a cfg_pkt has been seen, ticks do not end the stay.
- R5: In DATA, acq_en=1 and sleep_req=0. A tick with task_pend=0 enters SLEEP. A tick with task_pend=1 keeps the node in DATA.
- R6: In SLEEP, sleep_req=1 and acq_en=0. The node returns to DATA on the sleep_len-th tick after it entered SLEEP.
- R7: pre_alarm in DATA or SLEEP enters ALARM. In ALARM, sleep_req=0 and acq_en=1, and ticks cause no change.
- R8: stop in LISTEN, DATA, SLEEP or ALARM returns the node to INIT on the next edge.
- R9: A command wins over a sleep entry in the same cycle, and stop wins over pre_alarm.
- R10: mode_chg is 1 for exactly those cycles in which the mode differs from its value in the previous cycle.
- R11: In INIT, cfg_pkt, start, pre_alarm and stop have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pkt | input | 1 | Configuration packet strobe |
| start | input | 1 | Start command strobe |
| pre_alarm | input | 1 | Pre-alarm command strobe |
| stop | input | 1 | Stop command strobe |
| tick | input | 1 | 1 ms scheduler tick, one cycle wide |
| task_pend | input | 1 | A scheduled task is waiting |
| wake_ivl | input | TICK_W | Wake interval in INIT, in ticks |
| sleep_len | input | TICK_W | Sleep length in SLEEP, in ticks |
| mode | output | 3 | Current mode code |
| sleep_req | output | 1 | Request to power down |
| acq_en | output | 1 | Acquisition enable |
| mode_chg | output | 1 | One-cycle pulse on each mode change |
| tmr_load | output | TICK_W | Interval loaded on entry to the current mode |

## Verification
Every result is due one edge after its cause, because each one comes from a register. A command or tick driven before edge k shows up in mode, sleep_req, acq_en, tmr_load and mode_chg just after edge k. The driver changes inputs on falling edges and queues one expected record per rising edge. The monitor compares each record on the following falling edge, so every sample falls midway between the cause and the next edge. Timer expiry is checked on the exact tick that should end an interval, and also on the tick before it, which must not.

// File: rtl/nms_pkg.sv
package nms_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_INIT   = 3'd0,
    M_LISTEN = 3'd1,
    M_DATA   = 3'd2,
    M_SLEEP  = 3'd3,
    M_ALARM  = 3'd4
  } mode_e;

  // one-hot command after priority resolution
  typedef struct packed {
    logic stop;
    logic alarm;
    logic start;
    logic cfg;
  } cmd_t;
endpackage

// File: rtl/nms_cmd_arb.sv
module nms_cmd_arb
  import nms_pkg::*;
(
  input  logic cfg_pkt,
  input  logic start,
  input  logic pre_alarm,
  input  logic stop,
  output cmd_t cmd
);
  // priority: stop > pre_alarm > start > cfg
  always_comb begin
    cmd       = '0;
    cmd.stop  = stop;
    cmd.alarm = pre_alarm & ~stop;
    cmd.start = start & ~stop & ~pre_alarm;
    cmd.cfg   = cfg_pkt & ~stop & ~pre_alarm & ~start;
  end
endmodule

// File: rtl/nms_interval_ctr.sv
module nms_interval_ctr #(
  parameter int TICK_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] rst_val,
  input  logic              load,
  input  logic [TICK_W-1:0] load_val,
  input  logic              tick,
  output logic              expired,
  output logic [TICK_W-1:0] load_q
);
  logic [TICK_W-1:0] cnt;

  // last tick of the interval: count at one or zero
  assign expired = tick && (cnt <= TICK_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= rst_val;
      load_q <= rst_val;
    end else if (load) begin
      cnt    <= load_val;
      load_q <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - TICK_W'(1);
    end
  end
endmodule

// File: rtl/nms_mode_fsm.sv
module nms_mode_fsm
  import nms_pkg::*;
#(
  parameter int TICK_W       = 19,
  parameter int LISTEN_TICKS = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              cmd,
  input  logic              tick,
  input  logic              task_pend,
  input  logic              expired,
  input  logic [TICK_W-1:0] wake_ivl,
  input  logic [TICK_W-1:0] sleep_len,
  output mode_e             cur,
  output logic              load,
  output logic [TICK_W-1:0] load_val,
  output logic              chg
);
  localparam logic [TICK_W-1:0] LISTEN_LD = TICK_W'(LISTEN_TICKS);

  mode_e nxt;
  logic  cfg_seen;

  always_comb begin
    nxt = cur;
    unique case (cur)
      M_INIT:   if (expired) nxt = M_LISTEN;
      M_LISTEN: begin
        if (cmd.stop)                    nxt = M_INIT;
        else if (cmd.start && cfg_seen)  nxt = M_DATA;
        else if (expired && !cfg_seen)   nxt = M_INIT;
      end
      M_DATA: begin
        if (cmd.stop)                    nxt = M_INIT;
        else if (cmd.alarm)              nxt = M_ALARM;
        else if (tick && !task_pend)     nxt = M_SLEEP;
      end
      M_SLEEP: begin
        if (cmd.stop)                    nxt = M_INIT;
        else if (cmd.alarm)              nxt = M_ALARM;
        else if (expired)                nxt = M_DATA;
      end
      M_ALARM:  if (cmd.stop) nxt = M_INIT;
      default:  nxt = M_INIT;
    endcase
  end

  assign load = (nxt != cur);

  always_comb begin
    unique case (nxt)
      M_INIT:   load_val = wake_ivl;
      M_LISTEN: load_val = LISTEN_LD;
      M_SLEEP:  load_val = sleep_len;
      default:  load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= M_INIT;
      chg      <= 1'b0;
      cfg_seen <= 1'b0;
    end else begin
      cur <= nxt;
      chg <= load;
      if (load)                          cfg_seen <= 1'b0;
      else if (cur == M_LISTEN && cmd.cfg) cfg_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/node_mode_seq.sv
module node_mode_seq
  import nms_pkg::*;
#(
  parameter int TICK_W       = 19,
  parameter int LISTEN_TICKS = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pkt,
  input  logic              start,
  input  logic              pre_alarm,
  input  logic              stop,
  input  logic              tick,
  input  logic              task_pend,
  input  logic [TICK_W-1:0] wake_ivl,
  input  logic [TICK_W-1:0] sleep_len,
  output logic [2:0]        mode,
  output logic              sleep_req,
  output logic              acq_en,
  output logic              mode_chg,
  output logic [TICK_W-1:0] tmr_load
);
  cmd_t              cmd;
  mode_e             cur;
  logic              load;
  logic              expired;
  logic [TICK_W-1:0] load_val;

  nms_cmd_arb u_arb (
    .cfg_pkt   (cfg_pkt),
    .start     (start),
    .pre_alarm (pre_alarm),
    .stop      (stop),
    .cmd       (cmd)
  );

  nms_interval_ctr #(.TICK_W(TICK_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .rst_val  (wake_ivl),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .expired  (expired),
    .load_q   (tmr_load)
  );

  nms_mode_fsm #(.TICK_W(TICK_W), .LISTEN_TICKS(LISTEN_TICKS)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .tick      (tick),
    .task_pend (task_pend),
    .expired   (expired),
    .wake_ivl  (wake_ivl),
    .sleep_len (sleep_len),
    .cur       (cur),
    .load      (load),
    .load_val  (load_val),
    .chg       (mode_chg)
  );

  assign mode      = cur;
  assign sleep_req = (cur == M_INIT) || (cur == M_SLEEP);
  assign acq_en    = (cur == M_DATA) || (cur == M_ALARM);
endmodule

// File: rtl/nms_checker.sv
module nms_checker (
  input logic       clk,
  input logic       rst,
  input logic       pre_alarm,
  input logic       stop,
  input logic       tick,
  input logic [2:0] mode,
  input logic       sleep_req,
  input logic       acq_en,
  input logic       mode_chg
);
  // R7: alarm keeps the node awake and acquiring
  assert_alarm_awake_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |-> (!sleep_req && acq_en));

  // R6: sleep asks for power-down and stops acquisition
  assert_sleep_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3) |-> (sleep_req && !acq_en));

  // R8: stop from any active mode lands in INIT
  assert_stop_to_init_R8: assert property (@(posedge clk) disable iff (rst)
    (stop && mode != 3'd0) |=> (mode == 3'd0));

  // R9: pre-alarm without stop beats a sleep entry in DATA
  assert_cmd_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && pre_alarm && !stop) |=> (mode == 3'd4));

  // R11: without a tick nothing leaves INIT
  assert_init_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && !tick) |=> (mode == 3'd0));

  // R10: the change pulse tracks mode differences
  assert_chg_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mode_chg == (mode != $past(mode))));
endmodule

bind node_mode_seq nms_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .pre_alarm (pre_alarm),
  .stop      (stop),
  .tick      (tick),
  .mode      (mode),
  .sleep_req (sleep_req),
  .acq_en    (acq_en),
  .mode_chg  (mode_chg)
);

// File: tb/node_mode_seq_tb.sv
module node_mode_seq_tb;
  localparam int TW   = 19;
  localparam int LT   = 4;
  localparam int WAKE = 3;
  localparam int SLP  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_pkt = 0, start = 0, pre_alarm = 0, stop = 0, tick = 0, task_pend = 0;
  logic [TW-1:0] wake_ivl  = TW'(WAKE);
  logic [TW-1:0] sleep_len = TW'(SLP);
  logic [2:0]    mode;
  logic          sleep_req, acq_en, mode_chg;
  logic [TW-1:0] tmr_load;

  always #5 clk = ~clk;

  node_mode_seq #(.TICK_W(TW), .LISTEN_TICKS(LT)) u_dut (
    .clk(clk), .rst(rst), .cfg_pkt(cfg_pkt), .start(start),
    .pre_alarm(pre_alarm), .stop(stop), .tick(tick), .task_pend(task_pend),
    .wake_ivl(wake_ivl), .sleep_len(sleep_len), .mode(mode),
    .sleep_req(sleep_req), .acq_en(acq_en), .mode_chg(mode_chg),
    .tmr_load(tmr_load)
  );

  typedef struct {
    logic [2:0] m;
    logic       chg;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         errors = 0;
  logic [2:0] prev_m = 3'd0;
  bit         done   = 0;

  // expected side outputs follow from the mode code (R1, R2, R5, R6, R7)
  function automatic logic [TW-1:0] ld_of(input logic [2:0] m);
    case (m)
      3'd0:    return TW'(WAKE);
      3'd1:    return TW'(LT);
      3'd3:    return TW'(SLP);
      default: return '0;
    endcase
  endfunction

  task automatic step(input bit c, s, pa, sp, tk, tp,
                      input logic [2:0] em, input string tag);
    exp_t e;
    cfg_pkt = c; start = s; pre_alarm = pa; stop = sp; tick = tk; task_pend = tp;
    @(posedge clk);
    e.m = em; e.chg = (em != prev_m); e.tag = tag;
    prev_m = em;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: one record per rising edge, compared mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic exp_sl, exp_aq;
        e = q.pop_front();
        exp_sl = (e.m == 3'd0) || (e.m == 3'd3);
        exp_aq = (e.m == 3'd2) || (e.m == 3'd4);
        checks++;
        if (mode !== e.m || sleep_req !== exp_sl || acq_en !== exp_aq ||
            mode_chg !== e.chg || tmr_load !== ld_of(e.m)) begin
          errors++;
          $display("FAIL %s actual mode=%0d sl=%0b aq=%0b chg=%0b ld=%0d expected mode=%0d sl=%0b aq=%0b chg=%0b ld=%0d",
                   e.tag, mode, sleep_req, acq_en, mode_chg, tmr_load,
                   e.m, exp_sl, exp_aq, e.chg, ld_of(e.m));
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic to_data(input string tag);
    step(0,0,0,0,1,0, 3'd0, tag);
    step(0,0,0,0,1,0, 3'd0, tag);
    step(0,0,0,0,1,0, 3'd1, tag);
    step(1,0,0,0,0,0, 3'd1, tag);
    step(0,1,0,0,0,0, 3'd2, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(0,0,0,0,0,0, 3'd0, "R1 reset state");
    // R11: commands in INIT are ignored
    step(1,0,0,0,0,0, 3'd0, "R11 cfg in INIT");
    step(0,1,0,0,0,0, 3'd0, "R11 start in INIT");
    step(0,0,1,0,0,0, 3'd0, "R11 prealarm in INIT");
    step(0,0,0,1,0,0, 3'd0, "R11 stop in INIT");
    // R2: wake after WAKE ticks
    step(0,0,0,0,1,0, 3'd0, "R2 tick 1");
    step(0,0,0,0,1,0, 3'd0, "R2 tick 2");
    step(0,0,0,0,1,0, 3'd1, "R2 tick 3 wakes");
    // R3: start before cfg ignored
    step(0,1,0,0,0,0, 3'd1, "R3 start without cfg");
    // R4: window expiry without cfg
    step(0,0,0,0,1,0, 3'd1, "R4 listen tick 1");
    step(0,0,0,0,1,0, 3'd1, "R4 listen tick 2");
    step(0,0,0,0,1,0, 3'd1, "R4 listen tick 3");
    step(0,0,0,0,1,0, 3'd0, "R4 listen expiry");
    step(0,0,0,0,1,0, 3'd0, "R2 tick 1 again");
    step(0,0,0,0,1,0, 3'd0, "R2 tick 2 again");
    step(0,0,0,0,1,0, 3'd1, "R2 wake again");
    step(1,0,0,0,0,0, 3'd1, "R3 cfg seen");
    for (int i = 0; i < LT + 1; i++)
      step(0,0,0,0,1,0, 3'd1, "R4 ticks ignored after cfg");
    step(0,1,0,0,0,0, 3'd2, "R3 start after cfg");
    // R5 / R6
    step(0,0,0,0,1,1, 3'd2, "R5 task pending stays");
    step(0,0,0,0,0,0, 3'd2, "R5 no tick stays");
    step(0,0,0,0,1,0, 3'd3, "R5 idle tick sleeps");
    step(0,0,0,0,1,0, 3'd3, "R6 sleep tick 1");
    step(0,0,0,0,1,0, 3'd2, "R6 sleep expiry");
    step(0,0,0,0,1,0, 3'd3, "R5 sleep again");
    // R7
    step(0,0,1,0,0,0, 3'd4, "R7 prealarm from sleep");
    step(0,0,0,0,1,0, 3'd4, "R7 alarm tick 1");
    step(0,0,0,0,1,0, 3'd4, "R7 alarm tick 2");
    step(0,1,0,0,0,0, 3'd4, "R7 start ignored in alarm");
    // R8
    step(0,0,0,1,0,0, 3'd0, "R8 stop from alarm");
    to_data("R3 to data");
    step(0,0,1,0,1,0, 3'd4, "R9 prealarm beats sleep");
    step(0,0,1,1,0,0, 3'd0, "R9 stop beats prealarm");
    to_data("R3 to data 2");
    step(0,0,0,1,1,0, 3'd0, "R8 stop beats sleep in data");
    to_data("R3 to data 3");
    step(0,0,0,0,1,0, 3'd3, "R5 enter sleep");
    step(0,0,0,1,0,0, 3'd0, "R8 stop from sleep");
    step(0,0,0,0,1,0, 3'd0, "R2 tick 1");
    step(0,0,0,0,1,0, 3'd0, "R2 tick 2");
    step(0,0,0,0,1,0, 3'd1, "R2 wake");
    step(0,0,0,1,0,0, 3'd0, "R8 stop from listen");
    step(0,0,0,0,0,0, 3'd0, "R10 steady no pulse");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule